// File: doc/BRIEF.md
# Half-Cycle Tone Discriminator

This block recovers a two-tone audio stream as a logic level. A comparator outside the chip turns the audio into a square wave, and that wave arrives on one input. The block treats every transition of the square wave, rising or falling, as a zero crossing. It measures the time from one crossing to the next on a one-microsecond timebase and classifies each half-cycle on its own. A short interval means the high tone (about 138 us per half-cycle) and a long interval means the low tone (about 207 us). The recovered level is driven high for the high tone and low for the low tone. Because the decision uses one half-cycle, it works even when a sub-period holds a fractional number of tone cycles.

Two indicator outputs report the quality of the input. The green output lights when the recent intervals fall inside the tolerance windows around the two tone periods. The red output lights when a signal is present but its intervals fit neither window. Each indicator stays lit for a hold time after its last qualifying crossing. When the input stops toggling for longer than a timeout, both indicators go dark and the recovered level keeps its last value.

Top module: `tone_disc`

## Requirements
- R1: The input passes through two flip-flops and a run-length filter. A new input level counts as a crossing only after it has held for DG_LEN consecutive clocks. A pulse shorter than DG_LEN clocks is discarded and leaves every output unchanged.
- R2: A rising transition and a falling transition each count as a zero crossing.
- R3: Intervals are counted in ticks of one microsecond, with one tick every CLK_PER_US clocks. The outputs respond in the clock that comes DG_LEN+3 clocks after the clock in which the input changed. With one clock per tick, the interval equals the number of clocks between two input toggles.
- R4: When a crossing is classified, an interval of THRESH_US (172) ticks or fewer drives the tone output to 1. An interval of 173 ticks or more drives it to 0.
- R5: An interval in [HI_US-TOL_US, HI_US+TOL_US] or [LO_US-TOL_US, LO_US+TOL_US] is valid; with the defaults these windows are 113..163 and 182..232. A valid interval lights green and turns red off. Any other classified interval lights red and turns green off. The two indicators are never on together.
- R6: An indicator stays on for exactly HOLD_US ticks after its last qualifying crossing, then turns off.
- R7: The interval counter saturates at TIMEOUT_US+1 ticks. Once that many ticks pass with no crossing, both indicators turn off and the tone output holds its value. The first crossing after that point is not classified: it only restarts timing. An interval of exactly TIMEOUT_US ticks is still classified.
- R8: Reset is synchronous and active high. After reset the tone output is 0, both indicators are off, and the counter is in the saturated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zc_in | input | 1 | Asynchronous comparator output, toggles at audio zero crossings |
| tone_o | output | 1 | Recovered level: 1 for the high tone, 0 for the low tone |
| red_o | output | 1 | Signal present, but the intervals fit neither tone |
| green_o | output | 1 | The intervals fit a valid two-tone stream |

## Verification
The hardest cases to reach from the ports are the ones where two timers meet. One is an indicator hold that runs out while the input is still toggling. The other is a gap that lands exactly on the saturation limit, where a single tick decides whether the next crossing is classified or only restarts timing. The bench overrides the timebase to one tick per clock and sets the hold time shorter than the timeout. This makes each tick a clock, so a 700-tick half-cycle shows green expiring before the next crossing. Half-cycles of exactly 1000 and 1001 ticks land on both sides of the saturation edge. A sub-filter-length glitch placed in the middle of a low-tone half-cycle checks that the interval timing is not disturbed.

// File: rtl/tdisc_pkg.sv
package tdisc_pkg;

    // One classified zero crossing
    typedef struct packed {
        logic fire;   // a crossing closed a measurable interval
        logic high;   // interval at or below the threshold
        logic valid;  // interval inside one of the tone windows
    } xing_evt_t;

    localparam int LAMP_GREEN = 0;
    localparam int LAMP_RED   = 1;
    localparam int LAMP_COUNT = 2;

    function automatic logic in_window(input int iv, input int center, input int tol);
        return (iv >= center - tol) && (iv <= center + tol);
    endfunction

endpackage

// File: rtl/tdisc_timebase.sv
module tdisc_timebase #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            logic [PW-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (rst || pre_q == PW'(DIV - 1)) pre_q <= '0;
                else                              pre_q <= pre_q + 1'b1;
            end
            assign tick = (pre_q == PW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/tdisc_edge.sv
module tdisc_edge #(
    parameter int DG_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic zc_in,
    output logic xing
);
    localparam int DGW = $clog2(DG_LEN + 1);

    logic            meta_q, sync_q, filt_q;
    logic [DGW-1:0]  run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            filt_q <= 1'b0;
            run_q  <= '0;
            xing   <= 1'b0;
        end else begin
            meta_q <= zc_in;
            sync_q <= meta_q;
            xing   <= 1'b0;
            if (sync_q == filt_q) begin
                run_q <= '0;
            end else if (run_q == DGW'(DG_LEN - 1)) begin
                filt_q <= sync_q;
                run_q  <= '0;
                xing   <= 1'b1;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // R1
    edge_gap_chk: assert property (@(posedge clk) disable iff (rst)
        xing |=> !xing);
endmodule

// File: rtl/tdisc_interval.sv
module tdisc_interval
    import tdisc_pkg::*;
#(
    parameter int TIMEOUT_US = 1000,
    parameter int THRESH_US  = 172,
    parameter int HI_US      = 138,
    parameter int LO_US      = 207,
    parameter int TOL_US     = 25
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      xing,
    output xing_evt_t evt,
    output logic      absent
);
    localparam int SAT = TIMEOUT_US + 1;
    localparam int CW  = $clog2(SAT + 1);

    logic [CW-1:0] span_q;

    always_ff @(posedge clk) begin
        if (rst)                           span_q <= CW'(SAT);
        else if (xing)                     span_q <= tick ? CW'(1) : '0;
        else if (tick && !absent)          span_q <= span_q + 1'b1;
    end

    assign absent    = (span_q == CW'(SAT));
    assign evt.fire  = xing && !absent;
    assign evt.high  = int'(span_q) <= THRESH_US;
    assign evt.valid = in_window(int'(span_q), HI_US, TOL_US) ||
                       in_window(int'(span_q), LO_US, TOL_US);

    // R7
    sat_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(span_q) <= SAT);
endmodule

// File: rtl/tdisc_lamp.sv
module tdisc_lamp #(
    parameter int HOLD_US = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic absent,
    input  logic load,
    input  logic clear,
    output logic on
);
    localparam int HW = $clog2(HOLD_US + 1);

    logic [HW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst || absent)            left_q <= '0;
        else if (load)                left_q <= HW'(HOLD_US);
        else if (clear)               left_q <= '0;
        else if (tick && left_q != 0) left_q <= left_q - 1'b1;
    end

    assign on = (left_q != '0);
endmodule

// File: rtl/tone_disc.sv
module tone_disc
    import tdisc_pkg::*;
#(
    parameter int CLK_PER_US = 50,
    parameter int DG_LEN     = 4,
    parameter int THRESH_US  = 172,
    parameter int HI_US      = 138,
    parameter int LO_US      = 207,
    parameter int TOL_US     = 25,
    parameter int TIMEOUT_US = 1000,
    parameter int HOLD_US    = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic zc_in,
    output logic tone_o,
    output logic red_o,
    output logic green_o
);
    logic      tick, xing, absent;
    xing_evt_t evt;
    logic [LAMP_COUNT-1:0] ld, lit;

    tdisc_timebase #(.DIV(CLK_PER_US)) u_tb (
        .clk(clk), .rst(rst), .tick(tick));

    tdisc_edge #(.DG_LEN(DG_LEN)) u_edge (
        .clk(clk), .rst(rst), .zc_in(zc_in), .xing(xing));

    tdisc_interval #(
        .TIMEOUT_US(TIMEOUT_US), .THRESH_US(THRESH_US),
        .HI_US(HI_US), .LO_US(LO_US), .TOL_US(TOL_US)
    ) u_iv (
        .clk(clk), .rst(rst), .tick(tick), .xing(xing),
        .evt(evt), .absent(absent));

    always_ff @(posedge clk) begin
        if (rst)           tone_o <= 1'b0;
        else if (evt.fire) tone_o <= evt.high;
    end

    assign ld[LAMP_GREEN] = evt.fire &&  evt.valid;
    assign ld[LAMP_RED]   = evt.fire && !evt.valid;

    generate
        for (genvar i = 0; i < LAMP_COUNT; i++) begin : g_lamp
            tdisc_lamp #(.HOLD_US(HOLD_US)) u_lamp (
                .clk(clk), .rst(rst), .tick(tick), .absent(absent),
                .load(ld[i]), .clear(ld[LAMP_COUNT-1-i]), .on(lit[i]));
        end
    endgenerate

    assign green_o = lit[LAMP_GREEN];
    assign red_o   = lit[LAMP_RED];

    // R5
    lamp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({red_o, green_o}));

    // R5
    green_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(green_o) |-> $past(ld[LAMP_GREEN]));

    // R7
    dark_on_absent_chk: assert property (@(posedge clk) disable iff (rst)
        absent |=> (!green_o && !red_o));

    // R7
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        absent |=> $stable(tone_o));
endmodule

// File: tb/tone_disc_test.sv
module tone_disc_test;
    localparam int DG   = 4;
    localparam int TOUT = 1000;
    localparam int HOLD = 400;
    localparam int LAT  = DG + 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic zc  = 1'b0;
    logic tone_o, red_o, green_o;

    always #2.5 clk = ~clk;

    tone_disc #(
        .CLK_PER_US(1), .DG_LEN(DG), .TIMEOUT_US(TOUT), .HOLD_US(HOLD)
    ) uut (
        .clk(clk), .rst(rst), .zc_in(zc),
        .tone_o(tone_o), .red_o(red_o), .green_o(green_o));

    int checks = 0;
    int fails  = 0;
    string phase = "R8";

    // behavioural reference model
    int cyc = 0;
    int due[$];
    int last_u = -1;
    bit m_tone = 0;
    int g_until = -1;
    int r_until = -1;

    always @(posedge clk) begin
        cyc <= cyc + 1;
    end

    always @(posedge clk) begin
        int now;
        now = cyc + 1;
        if (due.size() > 0 && due[0] == now) begin
            void'(due.pop_front());
            if (last_u >= 0 && now - last_u <= TOUT) begin
                int iv;
                bit ok;
                iv = now - last_u;
                m_tone = (iv <= 172);
                ok = (iv >= 113 && iv <= 163) || (iv >= 182 && iv <= 232);
                if (ok) begin g_until = now + HOLD - 1; r_until = -1; end
                else    begin r_until = now + HOLD - 1; g_until = -1; end
            end
            last_u = now;
        end else if (last_u >= 0 && now - last_u >= TOUT + 1) begin
            g_until = -1;
            r_until = -1;
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk(phase, "tone",  tone_o,  m_tone);
            chk(phase, "green", green_o, int'(cyc <= g_until));
            chk(phase, "red",   red_o,   int'(cyc <= r_until));
        end
    end

    task automatic waitc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic half(int len);
        @(negedge clk);
        zc = ~zc;
        due.push_back(cyc + LAT);
        waitc(len - 1);
    endtask

    task automatic glitch(int w);
        @(negedge clk);
        zc = ~zc;
        waitc(w);
        zc = ~zc;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        summary();
    end

    initial begin
        waitc(6);
        // R8: state while and just after reset
        chk("R8", "tone",  tone_o,  0);
        chk("R8", "green", green_o, 0);
        chk("R8", "red",   red_o,   0);
        rst = 1'b0;
        waitc(20);

        // R2: rising and falling crossings alike, steady high tone
        phase = "R2";
        for (int i = 0; i < 8; i++) half(138);

        // R3: alternating tone groups at the measured interval
        phase = "R3";
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 6; i++) half(138);
            for (int i = 0; i < 8; i++) half(207);
        end

        // R4: threshold edges 172 / 173
        phase = "R4";
        half(172); half(173); half(172); half(173); half(138);

        // R5: window edges on both tones
        phase = "R5";
        half(113); half(112); half(163); half(164);
        half(182); half(181); half(232); half(233); half(138);

        // R1: short glitch inside a low-tone half-cycle
        phase = "R1";
        half(207);
        @(negedge clk); zc = ~zc; due.push_back(cyc + LAT);
        waitc(99);
        glitch(DG - 1);
        waitc(104);
        half(207); half(207);

        // R6: hold expiry while still toggling
        phase = "R6";
        half(138); half(138); half(700); half(700); half(138); half(207);

        // R7: absence, timeout edges, restart
        phase = "R7";
        half(207); half(1300); half(138); half(138);
        half(1000); half(138); half(1001); half(138); half(138);
        waitc(1200);
        half(207); half(207);
        waitc(60);
        summary();
    end
endmodule